// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down correction pulses from the phase/frequency detector and measures each pulse in ticks of a fast sampling clock. A strobe marks the end of every reference cycle. At each strobe the measured width is compared with one of two programmable tick counts. The tight entry threshold applies while the loop is still hunting. The wider exit threshold applies once lock has been declared.

Lock is declared only after five good reference cycles in a row. A single bad cycle during hunting throws away the run. Once locked, a single cycle whose error is beyond the exit threshold drops the flag. A power-down input forces the flag low and clears all progress. The flag moves only at strobes, reset or power-down, so it never toggles in the middle of a reference cycle.

Top module: `hyst_lock_detect`

## Requirements
- R1: The width of a reference cycle is the number of sampling-clock rising edges at which `up` or `dn` is high. Counting starts at the edge after the previous strobe and includes the strobe edge itself. The width saturates at 2^WIDTH_W-1 (63 by default) and never wraps.
- R2: While unlocked, a cycle is good when its width is strictly less than `entry_thr`. `locked` goes high on the clock edge of the fifth consecutive good strobe, and is visible right after that edge.
- R3: While unlocked, a strobe whose width is at least `entry_thr` clears the consecutive-good run to zero. Five new good cycles are then needed.
- R4: While locked, a strobe whose width is greater than `exit_thr` drops `locked` at that edge. A width less than or equal to `exit_thr` keeps lock.
- R5: An edge at which `pwr_down` is high forces `locked` low after that edge. It also clears the good-run count and the width accumulator, so only pulse edges after `pwr_down` falls count toward the next width.
- R6: `locked` changes only at edges where `ref_strobe` or `pwr_down` is high (or in reset). It stays constant between strobes.
- R7: `rst` is synchronous and active high. It leaves `locked` low and all counts cleared.
- R8: The good-run count never exceeds GOOD_RUN (5).
- R9: Up pulses and down pulses are measured alike. A loop corrected only by down pulses locks under the same rule as one corrected only by up pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| up | input | 1 | Pump-up pulse from the phase detector |
| dn | input | 1 | Pump-down pulse from the phase detector |
| ref_strobe | input | 1 | One-tick pulse on the last tick of each reference cycle |
| entry_thr | input | WIDTH_W | Entry threshold in ticks (width must be below it) |
| exit_thr | input | WIDTH_W | Exit threshold in ticks (width above it loses lock) |
| pwr_down | input | 1 | Power-down: forces unlock and clears state |
| locked | output | 1 | Lock flag |

## Verification
The following are checked as properties on every cycle:
- the flag never moves between strobes;
- power-down always leaves the flag low with an empty run;
- a rising flag is always preceded by a run of exactly GOOD_RUN-1 good cycles plus a good strobe;
- a failing exit strobe always unlocks;
- the width accumulator and the run count never wrap or overshoot.

Some properties only the bench scenarios can show:
- the exact threshold boundaries (width equal to the entry or exit value);
- saturation of very long pulses against a large entry threshold;
- a bad cycle in the middle of a run, which makes the count restart;
- partial-cycle power-down, which discards the pulse edges it covered.

The bench shows these by sweeping entry and exit widths against a model in the bench.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int DEF_WIDTH_W  = 6;
    localparam int DEF_GOOD_RUN = 5;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    // Per-strobe judgement handed from the comparator to the qualifier
    typedef struct packed {
        logic fire;        // a reference cycle ends on this edge
        logic pass_entry;  // width strictly below the entry threshold
        logic fail_exit;   // width strictly above the exit threshold
    } verdict_t;

endpackage

// File: rtl/ld_pulse_meter.sv
module ld_pulse_meter #(
    parameter int WIDTH_W = lockdet_pkg::DEF_WIDTH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down,
    input  logic               up,
    input  logic               dn,
    input  logic               ref_strobe,
    output logic [WIDTH_W-1:0] width_now
);
    localparam logic [WIDTH_W-1:0] SAT_MAX = {WIDTH_W{1'b1}};

    logic [WIDTH_W-1:0] acc;
    logic               active;

    assign active = up | dn;

    // Width including the current tick, saturating at all-ones
    always_comb begin
        if (acc == SAT_MAX) width_now = SAT_MAX;
        else                width_now = acc + {{(WIDTH_W-1){1'b0}}, active};
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_down || ref_strobe) acc <= '0;
        else                               acc <= width_now;
    end

    // R1
    sat_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_strobe && !pwr_down) |=> (acc >= $past(acc)));

    // R5
    pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (acc == '0));

endmodule

// File: rtl/ld_judge.sv
module ld_judge #(
    parameter int WIDTH_W = lockdet_pkg::DEF_WIDTH_W
) (
    input  logic                  ref_strobe,
    input  logic [WIDTH_W-1:0]    width_now,
    input  logic [WIDTH_W-1:0]    entry_thr,
    input  logic [WIDTH_W-1:0]    exit_thr,
    output lockdet_pkg::verdict_t verdict
);
    always_comb begin
        verdict.fire       = ref_strobe;
        verdict.pass_entry = (width_now < entry_thr);
        verdict.fail_exit  = (width_now > exit_thr);
    end
endmodule

// File: rtl/ld_qualifier.sv
module ld_qualifier #(
    parameter int GOOD_RUN = lockdet_pkg::DEF_GOOD_RUN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_down,
    input  lockdet_pkg::verdict_t verdict,
    output logic                  locked
);
    import lockdet_pkg::*;

    localparam int RUN_W = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(GOOD_RUN);

    lock_state_e      state;
    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            state   <= ST_HUNT;
            run_cnt <= '0;
        end else if (verdict.fire) begin
            case (state)
                ST_HUNT: begin
                    if (!verdict.pass_entry) begin
                        run_cnt <= '0;
                    end else if (run_cnt == RUN_LAST) begin
                        state   <= ST_LOCKED;
                        run_cnt <= RUN_FULL;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (verdict.fail_exit) begin
                        state   <= ST_HUNT;
                        run_cnt <= '0;
                    end
                end
                default: begin
                    state   <= ST_HUNT;
                    run_cnt <= '0;
                end
            endcase
        end
    end

    assign locked = (state == ST_LOCKED);

    // R2
    lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(verdict.fire && verdict.pass_entry && run_cnt == RUN_LAST));

    // R3
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && verdict.fire && !verdict.pass_entry) |=> (run_cnt == '0));

    // R4
    lock_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && verdict.fire && verdict.fail_exit && !pwr_down) |=> !locked);

    // R5
    pd_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!locked && run_cnt == '0));

    // R6
    no_glitch_chk: assert property (@(posedge clk) disable iff (rst)
        (!verdict.fire && !pwr_down) |=> $stable(locked));

    // R8
    run_sat_chk: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_FULL);

endmodule

// File: rtl/hyst_lock_detect.sv
module hyst_lock_detect #(
    parameter int WIDTH_W  = lockdet_pkg::DEF_WIDTH_W,
    parameter int GOOD_RUN = lockdet_pkg::DEF_GOOD_RUN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               up,
    input  logic               dn,
    input  logic               ref_strobe,
    input  logic [WIDTH_W-1:0] entry_thr,
    input  logic [WIDTH_W-1:0] exit_thr,
    input  logic               pwr_down,
    output logic               locked
);
    logic [WIDTH_W-1:0]    width_now;
    lockdet_pkg::verdict_t verdict;

    ld_pulse_meter #(.WIDTH_W(WIDTH_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .pwr_down   (pwr_down),
        .up         (up),
        .dn         (dn),
        .ref_strobe (ref_strobe),
        .width_now  (width_now)
    );

    ld_judge #(.WIDTH_W(WIDTH_W)) u_judge (
        .ref_strobe (ref_strobe),
        .width_now  (width_now),
        .entry_thr  (entry_thr),
        .exit_thr   (exit_thr),
        .verdict    (verdict)
    );

    ld_qualifier #(.GOOD_RUN(GOOD_RUN)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .verdict  (verdict),
        .locked   (locked)
    );

    // R7
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !locked);

endmodule

// File: tb/hyst_lock_detect_test.sv
module hyst_lock_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int WW         = 6;
    localparam int RUN        = 5;
    localparam int SATV       = (1 << WW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up = 1'b0, dn = 1'b0, ref_strobe = 1'b0, pwr_down = 1'b0;
    logic [WW-1:0] entry_thr = '0, exit_thr = '0;
    logic          locked;

    int  nchk = 0, nfail = 0;
    bit  m_lk = 1'b0;
    int  m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyst_lock_detect #(.WIDTH_W(WW), .GOOD_RUN(RUN)) uut (
        .clk(clk), .rst(rst), .up(up), .dn(dn), .ref_strobe(ref_strobe),
        .entry_thr(entry_thr), .exit_thr(exit_thr), .pwr_down(pwr_down),
        .locked(locked)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s locked=%0b expected=%0b", tag, got, exp);
        end
    endtask

    // Expected lock decision at a strobe, from the requirements
    task automatic model(input int wid_raw);
        int wid;
        wid = (wid_raw > SATV) ? SATV : wid_raw;
        if (!m_lk) begin
            if (wid < int'(entry_thr)) begin
                if (m_run == RUN - 1) begin m_lk = 1'b1; m_run = RUN; end
                else m_run++;
            end else begin
                m_run = 0;
            end
        end else if (wid > int'(exit_thr)) begin
            m_lk = 1'b0; m_run = 0;
        end
    endtask

    // One reference cycle of len ticks; pulse high for first w ticks;
    // power-down held for the first pd_ticks ticks.
    task automatic run_cyc(input int len, input int w, input bit use_dn,
                           input int pd_ticks, input string tag);
        bit prev;
        int eff;
        prev = m_lk;
        for (int k = 0; k < len; k++) begin
            up         = !use_dn && (k < w);
            dn         = use_dn && (k < w);
            pwr_down   = (k < pd_ticks);
            ref_strobe = (k == len - 1);
            @(negedge clk);
            if (k == len/2 && pd_ticks == 0 && k != len - 1)
                chk(locked, prev, "R6 mid-cycle flag stable");
        end
        up = 1'b0; dn = 1'b0; pwr_down = 1'b0; ref_strobe = 1'b0;
        if (pd_ticks >= len) begin
            m_lk = 1'b0; m_run = 0;
        end else begin
            if (pd_ticks > 0) begin m_lk = 1'b0; m_run = 0; end
            eff = ((w < len) ? w : len) - pd_ticks;
            if (eff < 0) eff = 0;
            model(eff);
        end
        chk(locked, m_lk, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(locked, 1'b0, "R7 reset state");
        rst = 1'b0;
        @(negedge clk);
        chk(locked, 1'b0, "R7 after reset release");

        // Sweep of entry and exit widths over two threshold settings
        for (int cfg = 0; cfg < 2; cfg++) begin
            entry_thr = (cfg == 0) ? WW'(4) : WW'(7);
            exit_thr  = (cfg == 0) ? WW'(9) : WW'(12);
            for (int wa = 0; wa < 16; wa++) begin
                for (int wb = 0; wb < 16; wb++) begin
                    run_cyc(16, 0, 1'b0, 16, "R5 power-down unlocks");
                    for (int i = 0; i < RUN; i++)
                        run_cyc(16, wa, bit'(wa % 2), 0, "R2 entry run (R1 width, R9 dn)");
                    run_cyc(16, wb, bit'(wb % 2), 0, "R4 exit threshold");
                end
            end
        end

        // R3: a bad cycle in the middle of the run restarts the count
        entry_thr = WW'(4); exit_thr = WW'(9);
        run_cyc(16, 0, 1'b0, 16, "R5 clear");
        for (int i = 0; i < 4; i++) run_cyc(16, 2, 1'b0, 0, "R3 run before fault");
        run_cyc(16, 6, 1'b0, 0, "R3 faulting cycle");
        for (int i = 0; i < 4; i++) run_cyc(16, 2, 1'b0, 0, "R3 not locked after restart");
        run_cyc(16, 2, 1'b0, 0, "R3 locks on fifth fresh cycle");
        chk(locked, 1'b1, "R3 locked after restart");

        // R5: partial power-down discards earlier pulse edges and the run
        run_cyc(16, 12, 1'b0, 10, "R5 partial power-down cycle");
        for (int i = 0; i < 4; i++) run_cyc(16, 2, 1'b0, 0, "R5 fresh run");
        chk(locked, 1'b1, "R5 run restarted from zero");

        // R9: down pulses only
        run_cyc(16, 0, 1'b0, 16, "R5 clear");
        for (int i = 0; i < RUN; i++) run_cyc(16, 3, 1'b1, 0, "R9 down-only run");
        chk(locked, 1'b1, "R9 down-only locks");
        run_cyc(16, 11, 1'b1, 0, "R9 down-only exit");

        // R1: saturation of long pulses
        entry_thr = WW'(40); exit_thr = WW'(50);
        run_cyc(16, 0, 1'b0, 16, "R5 clear");
        for (int i = 0; i < RUN; i++) run_cyc(110, 100, 1'b0, 0, "R1 saturated width is bad");
        chk(locked, 1'b0, "R1 no lock on saturated width");
        for (int i = 0; i < RUN; i++) run_cyc(110, 39, 1'b0, 0, "R1 long good width");
        chk(locked, 1'b1, "R1 lock with width 39");
        run_cyc(110, 100, 1'b0, 0, "R1 saturated width exits");

        // R7: reset while locked
        entry_thr = WW'(4); exit_thr = WW'(9);
        for (int i = 0; i < RUN; i++) run_cyc(16, 1, 1'b0, 0, "R2 relock");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(locked, 1'b0, "R7 reset while locked");
        rst = 1'b0; m_lk = 1'b0; m_run = 0;
        for (int i = 0; i < RUN - 1; i++) run_cyc(16, 1, 1'b0, 0, "R7 count cleared by reset");
        run_cyc(16, 1, 1'b0, 0, "R7 lock after full run");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule